// File: doc/BRIEF.md
# Multithreaded Branch Target Buffer

This block is a direct-mapped table of predicted branch targets that several hardware threads share. Each slot keeps a valid flag, a partial address tag, the thread number that wrote it and the predicted target. The fetch stage presents a fetch address and a thread number on the lookup port. In the same cycle, with no clock edge in between, it receives a hit flag and the stored target.

When a branch resolves, the update port writes that branch's target into its slot on the next rising clock edge. The write replaces whatever the slot held before. A flush input, and the reset, mark every slot empty.

The thread number is mixed into the upper slot-select bits with an XOR. It is also kept in each slot and compared on every lookup. Threads therefore spread over one table, and one thread never takes another thread's prediction.

Top module: `btb_core`

## Requirements
- R1: `ENTRIES` must be a power of two and at least 2, and no smaller than `NUM_THREADS`. `INST_SHIFT + log2(ENTRIES) + TAG_BITS` must fit in `ADDR_W`. Any other setting stops elaboration.
- R2: The slot is chosen by this formula: `slot = ((pc >> INST_SHIFT) ^ (tid << (log2(ENTRIES) - floor(log2(NUM_THREADS))))) & (ENTRIES-1)`. With the defaults, a lookup of `pc ^ 0x10` by thread 0 and a lookup of `pc` by thread 1 select the same slot.
- R3: The tag is the `TAG_BITS` address bits that start at bit `INST_SHIFT + log2(ENTRIES)`, which is bits 6 to 13 with the defaults. Address bits above the tag do not change the lookup result.
- R4: A lookup hits only when the selected slot is valid, its stored tag equals the computed tag, and its stored thread number equals `lk_tid`.
- R5: On a miss, `lk_hit` is 0 and `lk_target` is all zeros.
- R6: A slot written by `up_en` takes on the new thread, tag and target at the next rising edge, whatever it held before. A lookup of the same address and thread then hits and returns the new target.
- R7: After reset (`rst_n` low) or after a cycle with `flush` high, every lookup misses until a new update is written.
- R8: When `flush` and `up_en` are both high in the same cycle, the flush takes effect and the update is dropped.
- R9: A lookup made in the same cycle as an update to the same slot returns the slot's contents from before the update.
- R10: With `NUM_THREADS = 1` the thread input is 1 bit wide and the XOR term is zero, so the slot equals `(pc >> INST_SHIFT) & (ENTRIES-1)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| flush | input | 1 | Clears all valid flags at the next edge |
| lk_pc | input | ADDR_W | Fetch address to look up |
| lk_tid | input | max(1,clog2(NUM_THREADS)) | Thread making the lookup |
| lk_hit | output | 1 | Lookup found a matching slot |
| lk_target | output | TARGET_W | Stored target on a hit, zero on a miss |
| up_en | input | 1 | Write the update port's slot at the next edge |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_tid | input | max(1,clog2(NUM_THREADS)) | Thread of the resolved branch |
| up_target | input | TARGET_W | Target to store |

## Verification
The main instance is built with 16 slots, 8-bit tags, a 2-bit shift and 4 threads. With these values the XOR term moves the slot by 4 for each thread, so two different addresses from two threads can be steered into the same slot. That makes thread-only mismatches, cross-thread eviction and tag-only mismatches all reachable in a few cycles. A second instance built with one thread covers the variant without the hash.

// File: rtl/btb_pkg.sv
package btb_pkg;

   function automatic int floor_lg2(input int n);
      int r;
      r = 0;
      for (int v = n; v > 1; v = v / 2) r++;
      return r;
   endfunction

   function automatic int tid_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/btb_hash.sv
module btb_hash #(
   parameter int ADDR_W      = 32,
   parameter int ENTRIES     = 16,
   parameter int TAG_BITS    = 8,
   parameter int INST_SHIFT  = 2,
   parameter int NUM_THREADS = 4,
   localparam int IDX_W      = $clog2(ENTRIES),
   localparam int TID_W      = btb_pkg::tid_width(NUM_THREADS)
) (
   input  logic [ADDR_W-1:0]   pc,
   input  logic [TID_W-1:0]    tid,
   output logic [IDX_W-1:0]    idx,
   output logic [TAG_BITS-1:0] tag
);
   localparam int TAG_SHIFT = INST_SHIFT + IDX_W;
   localparam int THR_LG    = btb_pkg::floor_lg2(NUM_THREADS);
   localparam int MIX_SH    = IDX_W - THR_LG;

   logic [IDX_W-1:0] base_idx;

   assign base_idx = pc[INST_SHIFT +: IDX_W];
   assign tag      = pc[TAG_SHIFT +: TAG_BITS];

   generate
      if (NUM_THREADS > 1) begin : g_mix
         logic [IDX_W+TID_W-1:0] tid_sh;
         assign tid_sh = {{IDX_W{1'b0}}, tid} << MIX_SH;
         assign idx    = base_idx ^ tid_sh[IDX_W-1:0];
      end else begin : g_plain
         logic unused_tid;
         assign unused_tid = tid[0];
         assign idx        = base_idx;
      end
   endgenerate
endmodule

// File: rtl/btb_array.sv
module btb_array #(
   parameter int ENTRIES     = 16,
   parameter int TAG_BITS    = 8,
   parameter int TARGET_W    = 32,
   parameter int NUM_THREADS = 4,
   localparam int IDX_W      = $clog2(ENTRIES),
   localparam int TID_W      = btb_pkg::tid_width(NUM_THREADS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                we,
   input  logic [IDX_W-1:0]    w_idx,
   input  logic [TAG_BITS-1:0] w_tag,
   input  logic [TID_W-1:0]    w_tid,
   input  logic [TARGET_W-1:0] w_tgt,
   input  logic [IDX_W-1:0]    r_idx,
   output logic                r_valid,
   output logic [TAG_BITS-1:0] r_tag,
   output logic [TID_W-1:0]    r_tid,
   output logic [TARGET_W-1:0] r_tgt
);
   logic [ENTRIES-1:0]  valid_q;
   logic [TAG_BITS-1:0] tag_q [ENTRIES];
   logic [TID_W-1:0]    tid_q [ENTRIES];
   logic [TARGET_W-1:0] tgt_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (flush)
         valid_q <= '0;
      else if (we)
         valid_q[w_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we && !flush) begin
         tag_q[w_idx] <= w_tag;
         tid_q[w_idx] <= w_tid;
         tgt_q[w_idx] <= w_tgt;
      end
   end

   assign r_valid = valid_q[r_idx];
   assign r_tag   = tag_q[r_idx];
   assign r_tid   = tid_q[r_idx];
   assign r_tgt   = tgt_q[r_idx];

   // R6: at most one slot can become valid per edge
   p_one_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(valid_q) <= $past($countones(valid_q)) + 1);

   // R7 / R8: a flush leaves no slot valid
   p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush) |-> (valid_q == '0));
endmodule

// File: rtl/btb_core.sv
module btb_core #(
   parameter int ADDR_W      = 32,
   parameter int TARGET_W    = 32,
   parameter int ENTRIES     = 16,
   parameter int TAG_BITS    = 8,
   parameter int INST_SHIFT  = 2,
   parameter int NUM_THREADS = 4
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           flush,
   input  logic [ADDR_W-1:0]                              lk_pc,
   input  logic [btb_pkg::tid_width(NUM_THREADS)-1:0]     lk_tid,
   output logic                                           lk_hit,
   output logic [TARGET_W-1:0]                            lk_target,
   input  logic                                           up_en,
   input  logic [ADDR_W-1:0]                              up_pc,
   input  logic [btb_pkg::tid_width(NUM_THREADS)-1:0]     up_tid,
   input  logic [TARGET_W-1:0]                            up_target
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TID_W = btb_pkg::tid_width(NUM_THREADS);

   // R1: elaboration-time parameter checks
   generate
      if (!btb_pkg::is_pow2(ENTRIES) || ENTRIES < 2) begin : g_bad_entries
         $error("btb_core: ENTRIES must be a power of two, at least 2");
      end
      if (ENTRIES < NUM_THREADS || NUM_THREADS < 1) begin : g_bad_threads
         $error("btb_core: NUM_THREADS must be 1..ENTRIES");
      end
      if (INST_SHIFT + IDX_W + TAG_BITS > ADDR_W) begin : g_bad_tag
         $error("btb_core: tag field exceeds the address width");
      end
   endgenerate

   logic [IDX_W-1:0]    l_idx, u_idx;
   logic [TAG_BITS-1:0] l_tag, u_tag;
   logic                e_valid;
   logic [TAG_BITS-1:0] e_tag;
   logic [TID_W-1:0]    e_tid;
   logic [TARGET_W-1:0] e_tgt;

   btb_hash #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_BITS(TAG_BITS),
              .INST_SHIFT(INST_SHIFT), .NUM_THREADS(NUM_THREADS))
      u_lk_hash (.pc(lk_pc), .tid(lk_tid), .idx(l_idx), .tag(l_tag));

   btb_hash #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_BITS(TAG_BITS),
              .INST_SHIFT(INST_SHIFT), .NUM_THREADS(NUM_THREADS))
      u_up_hash (.pc(up_pc), .tid(up_tid), .idx(u_idx), .tag(u_tag));

   btb_array #(.ENTRIES(ENTRIES), .TAG_BITS(TAG_BITS), .TARGET_W(TARGET_W),
               .NUM_THREADS(NUM_THREADS))
      u_array (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .we(up_en), .w_idx(u_idx), .w_tag(u_tag), .w_tid(up_tid), .w_tgt(up_target),
         .r_idx(l_idx), .r_valid(e_valid), .r_tag(e_tag), .r_tid(e_tid), .r_tgt(e_tgt)
      );

   always_comb begin
      lk_hit    = e_valid && (e_tag == l_tag) && (e_tid == lk_tid);
      lk_target = lk_hit ? e_tgt : '0;
   end

   // R5: a miss never shows a target
   p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_target == '0));

   // R6: a written branch is found by the same address and thread next cycle
   p_update_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !flush) |=>
         (((lk_pc == $past(up_pc)) && (lk_tid == $past(up_tid)))
          -> (lk_hit && (lk_target == $past(up_target)))));

   // R7: nothing hits in the cycle after a flush
   p_flush_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);
endmodule

// File: tb/tb_btb_core.sv
module tb_btb_core;
   localparam int ENT = 16, TB = 8, SH = 2, NT = 4, AW = 32, TW = 32;
   localparam int TIDW = 2, TSH = 6, HS = 2;

   logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, up_en = 1'b0;
   logic [AW-1:0] lk_pc = '0, up_pc = '0;
   logic [TIDW-1:0] lk_tid = '0, up_tid = '0;
   logic [TW-1:0] up_target = '0, lk_target;
   logic lk_hit;

   logic s_up_en = 1'b0, s_hit;
   logic [AW-1:0] s_lk_pc = '0, s_up_pc = '0;
   logic [TW-1:0] s_up_tgt = '0, s_tgt;

   always #10 clk = ~clk;

   btb_core #(.ADDR_W(AW), .TARGET_W(TW), .ENTRIES(ENT), .TAG_BITS(TB),
              .INST_SHIFT(SH), .NUM_THREADS(NT)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .lk_pc(lk_pc), .lk_tid(lk_tid),
      .lk_hit(lk_hit), .lk_target(lk_target), .up_en(up_en), .up_pc(up_pc),
      .up_tid(up_tid), .up_target(up_target));

   btb_core #(.ADDR_W(AW), .TARGET_W(TW), .ENTRIES(ENT), .TAG_BITS(TB),
              .INST_SHIFT(SH), .NUM_THREADS(1)) dut_st (
      .clk(clk), .rst_n(rst_n), .flush(1'b0), .lk_pc(s_lk_pc), .lk_tid(1'b0),
      .lk_hit(s_hit), .lk_target(s_tgt), .up_en(s_up_en), .up_pc(s_up_pc),
      .up_tid(1'b0), .up_target(s_up_tgt));

   // reference model built from the requirements
   bit            m_v   [ENT];
   logic [TB-1:0] m_tag [ENT];
   logic [TIDW-1:0] m_tid [ENT];
   logic [TW-1:0] m_tgt [ENT];

   function automatic int midx(input logic [AW-1:0] pc, input logic [TIDW-1:0] t);
      return int'(((pc >> SH) ^ (AW'(t) << HS)) & (ENT - 1));
   endfunction
   function automatic logic [TB-1:0] mtag(input logic [AW-1:0] pc);
      return TB'(pc >> TSH);
   endfunction

   typedef struct { logic hit; logic [TW-1:0] tgt; string req; } exp_t;
   exp_t q[$];
   event ev;
   int n_chk = 0, n_bad = 0;

   // monitor: pops one expectation per lookup and compares
   initial forever begin
      exp_t e;
      @(ev);
      #2;
      e = q.pop_front();
      n_chk++;
      if (lk_hit !== e.hit || lk_target !== e.tgt) begin
         n_bad++;
         $display("FAIL %s: hit=%b target=%h expected hit=%b target=%h",
                  e.req, lk_hit, lk_target, e.hit, e.tgt);
      end
   end

   task automatic chk(input string req, input logic [TW:0] act, input logic [TW:0] ex);
      n_chk++;
      if (act !== ex) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, ex);
      end
   endtask

   // driver: one clock cycle with optional update/flush and one lookup
   task automatic cyc(input logic u, input logic [AW-1:0] upc, input logic [TIDW-1:0] ut,
                      input logic [TW-1:0] utg, input logic fl,
                      input logic [AW-1:0] lpc, input logic [TIDW-1:0] lt, input string req);
      exp_t e;
      int i;
      @(negedge clk);
      up_en = u; up_pc = upc; up_tid = ut; up_target = utg; flush = fl;
      lk_pc = lpc; lk_tid = lt;
      i = midx(lpc, lt);
      e.hit = m_v[i] && (m_tag[i] == mtag(lpc)) && (m_tid[i] == lt);
      e.tgt = e.hit ? m_tgt[i] : '0;
      e.req = req;
      q.push_back(e);
      -> ev;
      @(posedge clk);
      if (fl) begin
         for (int k = 0; k < ENT; k++) m_v[k] = 1'b0;
      end else if (u) begin
         i = midx(upc, ut);
         m_v[i] = 1'b1; m_tag[i] = mtag(upc); m_tid[i] = ut; m_tgt[i] = utg;
      end
      #1;
      up_en = 1'b0; flush = 1'b0;
   endtask

   task automatic look(input logic [AW-1:0] lpc, input logic [TIDW-1:0] lt, input string req);
      cyc(1'b0, '0, '0, '0, 1'b0, lpc, lt, req);
   endtask
   task automatic upd(input logic [AW-1:0] upc, input logic [TIDW-1:0] ut,
                      input logic [TW-1:0] utg, input string req);
      cyc(1'b1, upc, ut, utg, 1'b0, upc, ut, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int k = 0; k < ENT; k++) m_v[k] = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   localparam logic [AW-1:0] A = 32'h0000_1234;
   localparam logic [AW-1:0] P = A ^ 32'h10;          // same slot as A/tid1 for tid0
   localparam logic [AW-1:0] B = A ^ 32'h50;          // same slot, different tag

   initial begin
      do_reset();
      // R7: empty after reset, target zero (R5)
      look(A, 2'd1, "R7 reset miss");
      look(32'h0000_0000, 2'd0, "R5 miss zero");
      // R9: update and lookup the same slot in one cycle sees old (empty)
      upd(A, 2'd1, 32'hAAAA_0000, "R9 same-cycle old");
      look(A, 2'd1, "R6 hit after write");
      // R4: same slot and tag, different thread
      look(P, 2'd0, "R4 thread mismatch");
      look(A, 2'd2, "R4 other thread");
      // R3: bits above the tag ignored; a tag bit changes the result
      look(A | 32'h0010_0000, 2'd1, "R3 high bits ignored");
      look(A ^ 32'h40, 2'd1, "R3 tag mismatch");
      // R2: thread hash maps P/tid0 onto A/tid1's slot
      upd(P, 2'd0, 32'hBBBB_0000, "R2 write alias");
      look(A, 2'd1, "R2 evicted by alias");
      look(P, 2'd0, "R2 alias hit");
      // R6: overwrite with new tag
      upd(B, 2'd0, 32'hCCCC_0000, "R6 overwrite");
      look(P, 2'd0, "R6 old tag gone");
      look(B, 2'd0, "R6 new tag hit");
      // R9: new target not visible in the write cycle
      cyc(1'b1, B, 2'd0, 32'hDDDD_0000, 1'b0, B, 2'd0, "R9 old target");
      look(B, 2'd0, "R9 new target next cycle");
      // R8: flush beats update
      cyc(1'b1, 32'h0000_2000, 2'd3, 32'hEEEE_0000, 1'b1, B, 2'd0, "R8 pre-flush");
      look(32'h0000_2000, 2'd3, "R8 update dropped");
      look(B, 2'd0, "R7 flushed");
      // R2: fill from all threads, then read back
      for (int t = 0; t < NT; t++)
         for (int k = 0; k < 4; k++)
            upd(32'h0000_0100 + 32'(4 * k) + 32'(t << 8), 2'(t),
                32'h1000_0000 + 32'(t * 16 + k), "R2 fill");
      for (int t = 0; t < NT; t++)
         for (int k = 0; k < 4; k++)
            look(32'h0000_0100 + 32'(4 * k) + 32'(t << 8), 2'(t), "R2 readback");
      // R7: reset clears
      do_reset();
      look(32'h0000_0104, 2'd0, "R7 miss after reset");
      look(B, 2'd0, "R7 miss after reset 2");

      // R10: single-thread build, slot from address only
      @(negedge clk);
      s_up_en = 1'b1; s_up_pc = 32'h0000_0348; s_up_tgt = 32'h5555_0000;
      s_lk_pc = 32'h0000_0348;
      #2 chk("R10 empty before write", {s_hit, s_tgt}, {1'b0, 32'h0});
      @(negedge clk);
      s_up_en = 1'b0;
      #2 chk("R10 hit after write", {s_hit, s_tgt}, {1'b1, 32'h5555_0000});
      s_lk_pc = 32'h0000_0388;
      #2 chk("R10 tag mismatch", {s_hit, s_tgt}, {1'b0, 32'h0});

      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule